// File: doc/BRIEF.md
# Interrupt Event Queue Record Writer

This block sits behind the posted-write decoder of a PCIe root port. Each interrupt event it receives becomes one 64-byte record in a circular event queue in main memory. An event is an MSI with a 32-bit or 64-bit address, an MSI-X, a PCIe message or a legacy INTx assertion. The record is built as eight 64-bit words, and the block sends them one word per cycle through a plain memory write port. Word addresses are `{slot, word}`, so every record starts on a 64-byte boundary.

Software sees the queue through a small register interface:

- a head index that it advances after consuming records;
- a valid/enable bit;
- a sticky idle/error state;
- the tail index, which the block advances.

The block raises its interrupt output while the queue is enabled and holds at least one record. Two kinds of event are dropped:

- An event that arrives while the queue is disabled is dropped silently.
- An event that arrives while the queue is full is dropped and puts the queue in the error state.

Top module: `msi_eq_writer`

## Requirements
- R1: An accepted event in queue slot `s` produces eight memory writes. They go to word addresses `s*8+0` through `s*8+7`, in that order, on the eight consecutive clock edges that follow the acceptance edge.
- R2: Word 0 holds the record type in bits 7:0, and bits 63:8 are zero. The type codes are 1 = message, 2 = 32-bit MSI and 8 = INTx. A 64-bit-address MSI gets type 3. MSI and MSI-X events (`ev_kind_i` 0 and 1) take type 3 when `ev_addr64_i` is 1 and type 2 otherwise. Message events use `ev_kind_i` 2 and INTx events use 3.
- R3: Word 4 bits 15:0 hold the requester ID, and its bits 63:16 are zero. Word 5 holds the event address for MSI/MSI-X, with bits 63:32 forced to zero for type 2. For message and INTx records, word 5 is zero.
- R4: Word 6 depends on the event kind:
  - MSI: data[15:0] in bits 15:0, all higher bits zero.
  - MSI-X: data[31:0] in bits 31:0, all higher bits zero.
  - Message: target ID in bits 39:32, routing code in bits 18:16, message code in bits 7:0.
  - INTx: the pin in bits 1:0, with 0 = A, 1 = B, 2 = C and 3 = D.
  - In every case, all other bits of word 6 are zero.
- R5: Word 1 holds `ev_sysino_i` for INTx records and is zero for every other type. Word 3 holds `timestamp_i` as sampled on the acceptance edge, or zero when `TS_EN` is 0. Words 2 and 7 are zero.
- R6: `irq_o` is 1 exactly when `en_o` is 1 and `head_o` differs from `tail_o`.
- R7: An event accepted while `en_o` is 0 produces no memory write. It changes neither the tail nor the error state.
- R8: A message event is written only if its code is 0x18, 0x1B, 0x30, 0x31 or 0x33. Any other code is dropped with no write and no error.
- R9: An event that would be written while the queue is full (`tail+1 == head` modulo the depth) produces no write and sets `err_o`.
  - `err_o` holds until `err_clr_i` is pulsed.
  - If a set and a clear fall on the same edge, the set wins.
- R10: `ev_ready_o` is 1 while the block is idle and 0 during every cycle in which it writes a record word.
- R11: `tail_o` advances by one, modulo the depth, on the edge that writes word 7, and never earlier.
- R12: After reset, `head_o`, `tail_o`, `en_o` and `err_o` are 0. A pulse on `head_wr_i` loads `head_val_i` into the head, and a pulse on `en_wr_i` loads `en_val_i` into the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_valid_i | input | 1 | Event offered |
| ev_ready_o | output | 1 | Block can take an event |
| ev_kind_i | input | 2 | 0 MSI, 1 MSI-X, 2 message, 3 INTx |
| ev_addr64_i | input | 1 | MSI/MSI-X used a 64-bit address |
| ev_rid_i | input | 16 | Requester ID (bus, device, function) |
| ev_addr_i | input | 64 | MSI/MSI-X address |
| ev_data_i | input | 32 | MSI/MSI-X data |
| ev_msg_code_i | input | 8 | Message code |
| ev_msg_route_i | input | 3 | Message routing code |
| ev_msg_target_i | input | 8 | Message target ID |
| ev_intx_pin_i | input | 2 | INTx pin |
| ev_sysino_i | input | 64 | Software-defined interrupt number for INTx |
| timestamp_i | input | 64 | Free-running time value |
| head_wr_i | input | 1 | Load head index |
| head_val_i | input | DEPTH_W | New head index |
| en_wr_i | input | 1 | Load enable bit |
| en_val_i | input | 1 | New enable value |
| err_clr_i | input | 1 | Clear error state |
| mem_we_o | output | 1 | Record word write strobe |
| mem_addr_o | output | DEPTH_W+3 | Word address `{slot, word}` |
| mem_data_o | output | 64 | Record word |
| head_o | output | DEPTH_W | Head index |
| tail_o | output | DEPTH_W | Tail index |
| en_o | output | 1 | Queue enabled |
| err_o | output | 1 | Queue in error state |
| irq_o | output | 1 | Queue interrupt |

## Verification
Two functions can meet on one edge: the error set caused by an overflow and the clear pulse from software. To provoke this, the bench fills the queue to its last free slot and then offers one more event. It drives `err_clr_i` in the very cycle that this event is accepted. The bench judges the outcome by three things after that edge: `err_o` must still read 1, the write count must not change, and `tail_o` must not change. A separate clear pulse afterwards must then return `err_o` to 0.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;

  localparam int unsigned WORD_W    = 64;
  localparam int unsigned WORDS     = 8;
  localparam int unsigned WIDX_W    = $clog2(WORDS);

  typedef enum logic [1:0] {
    KIND_MSI  = 2'd0,
    KIND_MSIX = 2'd1,
    KIND_MSG  = 2'd2,
    KIND_INTX = 2'd3
  } ev_kind_e;

  localparam logic [7:0] TYPE_MSG   = 8'd1;
  localparam logic [7:0] TYPE_MSI32 = 8'd2;
  localparam logic [7:0] TYPE_MSI64 = 8'd3;
  localparam logic [7:0] TYPE_INTX  = 8'd8;

  typedef struct packed {
    ev_kind_e     kind;
    logic         addr64;
    logic [15:0]  rid;
    logic [63:0]  addr;
    logic [31:0]  data;
    logic [7:0]   code;
    logic [2:0]   route;
    logic [7:0]   target;
    logic [1:0]   pin;
    logic [63:0]  sysino;
    logic [63:0]  ts;
  } event_t;

  function automatic logic msg_code_ok(input logic [7:0] c);
    case (c)
      8'h18, 8'h1B, 8'h30, 8'h31, 8'h33: msg_code_ok = 1'b1;
      default:                           msg_code_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/msi_eq_fmt.sv
module msi_eq_fmt
  import msi_eq_pkg::*;
#(
  parameter bit TS_EN = 1'b1
) (
  input  event_t                ev_i,
  input  logic [WIDX_W-1:0]     widx_i,
  output logic [WORD_W-1:0]     word_o
);

  logic [7:0]        rec_type;
  logic [WORD_W-1:0] ts_word;
  logic              is_msi;

  assign is_msi = (ev_i.kind == KIND_MSI) || (ev_i.kind == KIND_MSIX);

  always_comb begin
    case (ev_i.kind)
      KIND_MSG:  rec_type = TYPE_MSG;
      KIND_INTX: rec_type = TYPE_INTX;
      default:   rec_type = ev_i.addr64 ? TYPE_MSI64 : TYPE_MSI32;
    endcase
  end

  generate
    if (TS_EN) begin : g_ts
      assign ts_word = ev_i.ts;
    end else begin : g_no_ts
      assign ts_word = '0;
    end
  endgenerate

  always_comb begin
    word_o = '0;
    case (widx_i)
      3'd0: word_o = {56'h0, rec_type};
      3'd1: word_o = (ev_i.kind == KIND_INTX) ? ev_i.sysino : '0;
      3'd3: word_o = ts_word;
      3'd4: word_o = {48'h0, ev_i.rid};
      3'd5: begin
        if (is_msi)
          word_o = ev_i.addr64 ? ev_i.addr : {32'h0, ev_i.addr[31:0]};
      end
      3'd6: begin
        case (ev_i.kind)
          KIND_MSI:  word_o = {48'h0, ev_i.data[15:0]};
          KIND_MSIX: word_o = {32'h0, ev_i.data};
          KIND_MSG:  word_o = {24'h0, ev_i.target, 13'h0, ev_i.route, 8'h0, ev_i.code};
          default:   word_o = {62'h0, ev_i.pin};
        endcase
      end
      default: word_o = '0;
    endcase
  end

endmodule

// File: rtl/msi_eq_ptrs.sv
module msi_eq_ptrs #(
  parameter int unsigned DEPTH_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               head_wr_i,
  input  logic [DEPTH_W-1:0] head_val_i,
  input  logic               en_wr_i,
  input  logic               en_val_i,
  input  logic               err_clr_i,
  input  logic               err_set_i,
  input  logic               tail_inc_i,
  output logic [DEPTH_W-1:0] head_o,
  output logic [DEPTH_W-1:0] tail_o,
  output logic               en_o,
  output logic               err_o,
  output logic               full_o,
  output logic               irq_o
);

  logic [DEPTH_W-1:0] head_q, tail_q, tail_nxt;
  logic               en_q, err_q;

  assign tail_nxt = tail_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (head_wr_i)  head_q <= head_val_i;
      if (tail_inc_i) tail_q <= tail_nxt;
      if (en_wr_i)    en_q   <= en_val_i;
      // set has priority over software clear
      if (err_set_i)      err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign en_o   = en_q;
  assign err_o  = err_q;
  assign full_o = (tail_nxt == head_q);
  assign irq_o  = en_q && (head_q != tail_q);

endmodule

// File: rtl/msi_eq_seq.sv
module msi_eq_seq
  import msi_eq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  event_t            ev_i,
  output logic              ev_ready_o,
  input  logic              en_i,
  input  logic              full_i,
  output logic              err_set_o,
  output logic              tail_inc_o,
  output logic              we_o,
  output logic [WIDX_W-1:0] widx_o,
  output event_t            ev_q_o
);

  typedef enum logic {ST_IDLE, ST_WRITE} st_e;

  st_e               st_q;
  logic [WIDX_W-1:0] cnt_q;
  event_t            ev_q;
  logic              accept, keep, start, last;

  assign ev_ready_o = (st_q == ST_IDLE);
  assign accept     = ev_valid_i && ev_ready_o;
  assign keep       = accept && en_i &&
                      ((ev_i.kind != KIND_MSG) || msg_code_ok(ev_i.code));
  assign start      = keep && !full_i;
  assign err_set_o  = keep && full_i;
  assign last       = (st_q == ST_WRITE) && (cnt_q == WIDX_W'(WORDS - 1));
  assign tail_inc_o = last;
  assign we_o       = (st_q == ST_WRITE);
  assign widx_o     = cnt_q;
  assign ev_q_o     = ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ev_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q  <= ST_WRITE;
          cnt_q <= '0;
          ev_q  <= ev_i;
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) st_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/msi_eq_writer.sv
module msi_eq_writer
  import msi_eq_pkg::*;
#(
  parameter int unsigned DEPTH_W = 2,
  parameter bit          TS_EN   = 1'b1,
  localparam int unsigned AW     = DEPTH_W + WIDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ev_valid_i,
  output logic               ev_ready_o,
  input  logic [1:0]         ev_kind_i,
  input  logic               ev_addr64_i,
  input  logic [15:0]        ev_rid_i,
  input  logic [63:0]        ev_addr_i,
  input  logic [31:0]        ev_data_i,
  input  logic [7:0]         ev_msg_code_i,
  input  logic [2:0]         ev_msg_route_i,
  input  logic [7:0]         ev_msg_target_i,
  input  logic [1:0]         ev_intx_pin_i,
  input  logic [63:0]        ev_sysino_i,
  input  logic [63:0]        timestamp_i,
  input  logic               head_wr_i,
  input  logic [DEPTH_W-1:0] head_val_i,
  input  logic               en_wr_i,
  input  logic               en_val_i,
  input  logic               err_clr_i,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [63:0]        mem_data_o,
  output logic [DEPTH_W-1:0] head_o,
  output logic [DEPTH_W-1:0] tail_o,
  output logic               en_o,
  output logic               err_o,
  output logic               irq_o
);

  event_t            ev_in, ev_q;
  logic              full, err_set, tail_inc;
  logic [WIDX_W-1:0] widx;

  always_comb begin
    ev_in        = '0;
    ev_in.kind   = ev_kind_e'(ev_kind_i);
    ev_in.addr64 = ev_addr64_i;
    ev_in.rid    = ev_rid_i;
    ev_in.addr   = ev_addr_i;
    ev_in.data   = ev_data_i;
    ev_in.code   = ev_msg_code_i;
    ev_in.route  = ev_msg_route_i;
    ev_in.target = ev_msg_target_i;
    ev_in.pin    = ev_intx_pin_i;
    ev_in.sysino = ev_sysino_i;
    ev_in.ts     = timestamp_i;
  end

  msi_eq_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_valid_i (ev_valid_i),
    .ev_i       (ev_in),
    .ev_ready_o (ev_ready_o),
    .en_i       (en_o),
    .full_i     (full),
    .err_set_o  (err_set),
    .tail_inc_o (tail_inc),
    .we_o       (mem_we_o),
    .widx_o     (widx),
    .ev_q_o     (ev_q)
  );

  msi_eq_ptrs #(.DEPTH_W(DEPTH_W)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_wr_i  (head_wr_i),
    .head_val_i (head_val_i),
    .en_wr_i    (en_wr_i),
    .en_val_i   (en_val_i),
    .err_clr_i  (err_clr_i),
    .err_set_i  (err_set),
    .tail_inc_i (tail_inc),
    .head_o     (head_o),
    .tail_o     (tail_o),
    .en_o       (en_o),
    .err_o      (err_o),
    .full_o     (full),
    .irq_o      (irq_o)
  );

  msi_eq_fmt #(.TS_EN(TS_EN)) u_fmt (
    .ev_i   (ev_q),
    .widx_i (widx),
    .word_o (mem_data_o)
  );

  assign mem_addr_o = {tail_o, widx};

endmodule

// File: rtl/msi_eq_writer_chk.sv
module msi_eq_writer_chk #(
  parameter int unsigned DEPTH_W = 2,
  localparam int unsigned AW     = DEPTH_W + 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ev_ready_o,
  input logic               err_clr_i,
  input logic               mem_we_o,
  input logic [AW-1:0]      mem_addr_o,
  input logic [63:0]        mem_data_o,
  input logic [DEPTH_W-1:0] head_o,
  input logic [DEPTH_W-1:0] tail_o,
  input logic               en_o,
  input logic               err_o,
  input logic               irq_o
);

  p_word_seq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[2:0] != 3'd7) |=>
      (mem_we_o && mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  p_type_hi_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[2:0] == 3'd0) |-> (mem_data_o[63:4] == '0));

  p_pad_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && (mem_addr_o[2:0] == 3'd2 || mem_addr_o[2:0] == 3'd7))
      |-> (mem_data_o == '0));

  p_irq_cond_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o || head_o == tail_o) |-> !irq_o);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);

  p_ready_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !ev_ready_o);

  p_tail_last_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_o != $past(tail_o)) |->
      ($past(mem_we_o) && $past(mem_addr_o[2:0]) == 3'd7));

endmodule

bind msi_eq_writer msi_eq_writer_chk #(.DEPTH_W(DEPTH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ev_ready_o (ev_ready_o),
  .err_clr_i  (err_clr_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .head_o     (head_o),
  .tail_o     (tail_o),
  .en_o       (en_o),
  .err_o      (err_o),
  .irq_o      (irq_o)
);

// File: tb/msi_eq_writer_tb_top.sv
module msi_eq_writer_tb_top;

  localparam int DW = 2;
  localparam int AW = DW + 3;

  typedef struct packed {
    logic [1:0]  kind;
    logic        a64;
    logic [15:0] rid;
    logic [63:0] addr;
    logic [31:0] data;
    logic [7:0]  code;
    logic [2:0]  route;
    logic [7:0]  target;
    logic [1:0]  pin;
    logic [63:0] sysino;
    logic [7:0]  exp_type;
    logic [63:0] exp_w6;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TABLE [NV] = '{
    '{2'd0, 1'b0, 16'h1A2B, 64'hDEAD_BEEF_1234_5678, 32'hABCD_9876, 8'h00, 3'd0, 8'h00, 2'd0,
      64'h55, 8'd2, 64'h0000_0000_0000_9876},
    '{2'd0, 1'b1, 16'h0308, 64'h0000_00F0_0000_1000, 32'h0000_4321, 8'h00, 3'd0, 8'h00, 2'd0,
      64'h0, 8'd3, 64'h0000_0000_0000_4321},
    '{2'd1, 1'b0, 16'hFF07, 64'hFFFF_0000_FEE0_0040, 32'hCAFE_F00D, 8'h00, 3'd0, 8'h00, 2'd0,
      64'h0, 8'd2, 64'h0000_0000_CAFE_F00D},
    '{2'd2, 1'b0, 16'h2210, 64'h1111_2222_3333_4444, 32'h0, 8'h30, 3'd5, 8'h5C, 2'd0,
      64'h0, 8'd1, 64'h0000_005C_0005_0030},
    '{2'd3, 1'b0, 16'h0101, 64'h0, 32'h0, 8'h00, 3'd0, 8'h00, 2'd2,
      64'h0000_0000_0000_0777, 8'd8, 64'h2},
    '{2'd2, 1'b1, 16'h4000, 64'h0, 32'hFFFF_FFFF, 8'h1B, 3'd0, 8'hA1, 2'd3,
      64'h99, 8'd1, 64'h0000_00A1_0000_001B}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic ev_valid_i = 0, ev_ready_o, ev_addr64_i = 0;
  logic [1:0] ev_kind_i = 0, ev_intx_pin_i = 0;
  logic [15:0] ev_rid_i = 0;
  logic [63:0] ev_addr_i = 0, ev_sysino_i = 0, timestamp_i = 0;
  logic [31:0] ev_data_i = 0;
  logic [7:0] ev_msg_code_i = 0, ev_msg_target_i = 0;
  logic [2:0] ev_msg_route_i = 0;
  logic head_wr_i = 0, en_wr_i = 0, en_val_i = 0, err_clr_i = 0;
  logic [DW-1:0] head_val_i = 0;
  logic mem_we_o, en_o, err_o, irq_o;
  logic [AW-1:0] mem_addr_o;
  logic [63:0] mem_data_o;
  logic [DW-1:0] head_o, tail_o;

  msi_eq_writer #(.DEPTH_W(DW), .TS_EN(1'b1)) dut_i (.*);

  int total = 0, bad = 0, wr_cnt = 0, rdy_during_wr = 0;
  logic [63:0] mem_m [2**AW];
  bit done = 0;

  always @(negedge clk_i) begin
    if (mem_we_o) begin
      mem_m[mem_addr_o] = mem_data_o;
      wr_cnt++;
      if (ev_ready_o) rdy_during_wr++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_word(input vec_t v, input int w, input logic [63:0] ts);
    case (w)
      0: return {56'h0, v.exp_type};
      1: return (v.kind == 2'd3) ? v.sysino : 64'h0;
      3: return ts;
      4: return {48'h0, v.rid};
      5: return (v.kind <= 2'd1) ? (v.a64 ? v.addr : {32'h0, v.addr[31:0]}) : 64'h0;
      6: return v.exp_w6;
      default: return 64'h0;
    endcase
  endfunction

  // called at a negedge while the block is idle; returns 1 ns after the accepting edge
  task automatic send(input vec_t v, input logic [63:0] ts, input bit clr);
    ev_kind_i = v.kind; ev_addr64_i = v.a64; ev_rid_i = v.rid; ev_addr_i = v.addr;
    ev_data_i = v.data; ev_msg_code_i = v.code; ev_msg_route_i = v.route;
    ev_msg_target_i = v.target; ev_intx_pin_i = v.pin; ev_sysino_i = v.sysino;
    timestamp_i = ts; ev_valid_i = 1'b1; err_clr_i = clr;
    @(posedge clk_i); #1;
    ev_valid_i = 1'b0; err_clr_i = 1'b0; timestamp_i = 64'hBAD0;
  endtask

  task automatic set_head(input logic [DW-1:0] h);
    head_val_i = h; head_wr_i = 1'b1;
    @(posedge clk_i); #1 head_wr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic set_en(input bit e);
    en_val_i = e; en_wr_i = 1'b1;
    @(posedge clk_i); #1 en_wr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic pulse_clr();
    err_clr_i = 1'b1;
    @(posedge clk_i); #1 err_clr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int w0;
    logic [DW-1:0] t0;
    vec_t bad_msg;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 reset state
    chk(head_o == 0 && tail_o == 0, "R12 reset ptrs", {head_o, tail_o}, 0);
    chk(en_o == 0 && err_o == 0, "R12 reset en/err", {en_o, err_o}, 0);
    chk(ev_ready_o == 1, "R10 idle ready", ev_ready_o, 1);
    chk(irq_o == 0, "R6 irq at reset", irq_o, 0);

    // R7 disabled queue drops
    send(TABLE[0], 64'h1, 0);
    repeat (9) @(negedge clk_i);
    chk(wr_cnt == 0 && tail_o == 0 && err_o == 0, "R7 drop while disabled", wr_cnt, 0);

    set_en(1);
    chk(en_o == 1, "R12 enable load", en_o, 1);

    // table walk: R1..R6, R11
    for (int i = 0; i < NV; i++) begin
      logic [63:0] ts;
      logic [DW-1:0] slot;
      ts = 64'h1000 + 64'(i);
      slot = tail_o;
      w0 = wr_cnt;
      send(TABLE[i], ts, 0);
      repeat (4) @(negedge clk_i);
      chk(tail_o == slot, "R11 tail held mid-record", tail_o, slot);
      chk(ev_ready_o == 0, "R10 ready low while writing", ev_ready_o, 0);
      repeat (5) @(negedge clk_i);
      chk(wr_cnt - w0 == 8, "R1 eight writes", wr_cnt - w0, 8);
      for (int w = 0; w < 8; w++) begin
        logic [63:0] e, a;
        e = exp_word(TABLE[i], w, ts);
        a = mem_m[{slot, 3'(w)}];
        chk(a == e, $sformatf("R1/R2/R3/R4/R5 row %0d word %0d", i, w), a, e);
      end
      chk(tail_o == DW'(slot + 1'b1), "R11 tail advanced", tail_o, slot + 1'b1);
      chk(irq_o == 1, "R6 irq non-empty", irq_o, 1);
      set_head(tail_o);
      chk(head_o == tail_o && irq_o == 0, "R12 head write / R6 irq clear", head_o, tail_o);
    end

    // R8 unsupported message code
    bad_msg = TABLE[3];
    bad_msg.code = 8'h20;
    w0 = wr_cnt; t0 = tail_o;
    send(bad_msg, 64'h5, 0);
    repeat (9) @(negedge clk_i);
    chk(wr_cnt == w0 && tail_o == t0 && err_o == 0, "R8 bad code dropped", wr_cnt - w0, 0);

    // fill queue to full (3 of 4 slots)
    for (int k = 0; k < 3; k++) begin
      send(TABLE[k], 64'h2000, 0);
      repeat (9) @(negedge clk_i);
    end
    t0 = tail_o; w0 = wr_cnt;
    chk(DW'(t0 + 1'b1) == head_o, "R9 queue full", t0 + 1'b1, head_o);

    // R6 disable hides irq
    chk(irq_o == 1, "R6 irq full", irq_o, 1);
    set_en(0);
    chk(irq_o == 0, "R6 irq off when disabled", irq_o, 0);
    set_en(1);

    // R9 overflow
    send(TABLE[4], 64'h3000, 0);
    @(negedge clk_i);
    chk(err_o == 1, "R9 overflow sets error", err_o, 1);
    repeat (9) @(negedge clk_i);
    chk(wr_cnt == w0 && tail_o == t0, "R9 overflow dropped", wr_cnt - w0, 0);
    chk(err_o == 1, "R9 error sticky", err_o, 1);
    pulse_clr();
    chk(err_o == 0, "R9 error cleared", err_o, 0);

    // R9 set and clear on the same edge: set wins
    send(TABLE[1], 64'h3001, 1);
    @(negedge clk_i);
    chk(err_o == 1, "R9 set beats clear", err_o, 1);
    repeat (9) @(negedge clk_i);
    chk(wr_cnt == w0 && tail_o == t0, "R9 same-cycle drop", wr_cnt - w0, 0);
    pulse_clr();
    chk(err_o == 0, "R9 cleared after collision", err_o, 0);

    // R10 ready never seen high during writes
    chk(rdy_during_wr == 0, "R10 ready during writes", rdy_during_wr, 0);

    finish_run();
  end

endmodule